// File: doc/BRIEF.md
# Thread Interrupt Steering with Reschedule Trigger

This block sits beside a multithreaded processor core and decides which hardware thread takes each external interrupt. Up to eight interrupt lines are captured into a pending set. Every clock the block looks for a pending line that at least one thread can accept. It then hands that line to the eligible thread that is running the least important work, which is the thread with the numerically largest priority. A thread that receives an interrupt is marked busy in exception mode and takes no further interrupts until software releases it.

A second function supports the operating system's task scheduler. Software loads a best-waiting priority, which is the priority of the most urgent task waiting for a thread. While scheduling assistance is enabled, the block raises a one-cycle reschedule request whenever some thread runs at a priority worse than that value. In the same cycle the block rearms the best-waiting register to its idle value, so the request fires only once. Both results are registered, so each output appears one clock after the inputs that cause it.

Top module: `steer_top`

## Requirements
- R1: After reset, `grant_vld` and `resched_req` are 0, `grant_thr` and `exc_mode` are all zero, no interrupt is pending, and `bestwait` reads 0x1ff.
- R2: Thread t can accept interrupt i only when all of these hold: `glb_ie` is 1, `thr_ie[t]` is 1, `exc_mode[t]` is 0, and mask bit `thr_mask[t*NIRQ+i]` is 0 (1 means masked).
- R3: Among the threads that can accept the chosen interrupt, the grant goes to the thread whose 9-bit priority `thr_prio[t*9 +: 9]` is numerically largest. On a tie the lowest thread index wins.
- R4: A high `irq_in[i]` at a clock edge makes line i pending. If it can be steered at that same edge, it is granted there. At most one line is granted per clock, and the winner is the lowest-numbered pending line that has at least one accepting thread.
- R5: A pending line with no accepting thread stays pending. It is granted at the first edge at which some thread can accept it.
- R6: A grant sets `exc_mode` of the chosen thread at the same edge. `exc_clr[t]` clears bit t. When a set and a clear of the same bit coincide, the set wins.
- R7: While `sched_en` is 1 and some thread's priority is numerically greater than `bestwait`, the next edge drives `resched_req` to 1 for one cycle and loads `bestwait` with 0x1ff.
- R8: While `sched_en` is 0, `resched_req` stays 0 and `bestwait` is not rearmed.
- R9: `bw_wr` loads `bw_wdata` into `bestwait` at the next edge. If a write and a rearm fall in the same cycle, the written value is kept.
- R10: `grant_vld` is a one-cycle pulse per grant. With it, `grant_thr` is one-hot on the chosen thread and `grant_irq` carries the line number. Without it, `grant_thr` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NIRQ | External interrupt lines, sampled each edge |
| glb_ie | input | 1 | Global interrupt enable |
| thr_ie | input | NTHR | Per-thread interrupt enable |
| thr_prio | input | NTHR*PW | Per-thread priority, thread t at bits t*PW |
| thr_mask | input | NTHR*NIRQ | Per-thread line masks, 1 = masked |
| exc_clr | input | NTHR | Software release of exception mode |
| sched_en | input | 1 | Enables the reschedule trigger |
| bw_wr | input | 1 | Write strobe for best-waiting priority |
| bw_wdata | input | PW | Best-waiting priority to write |
| grant_vld | output | 1 | A grant was made this cycle |
| grant_thr | output | NTHR | One-hot chosen thread |
| grant_irq | output | $clog2(NIRQ) | Granted line number |
| exc_mode | output | NTHR | Per-thread exception-mode state |
| resched_req | output | 1 | Reschedule interrupt pulse |
| bestwait | output | PW | Current best-waiting priority |

## Verification
Two collisions are provoked on purpose. In the first, one thread's priority is raised above the best-waiting value at the same moment an interrupt arrives. The bench then expects, at the same edge, a grant to that thread (it is now the lowest-priority one) and a reschedule pulse with `bestwait` back at 0x1ff. In the second, a software write to `bestwait` lands in the cycle a reschedule fires. The bench expects the pulse together with the written value, and then a second pulse once the new value is compared.

// File: rtl/steer_pkg.sv
package steer_pkg;
    localparam int unsigned DEF_NIRQ = 8;
    localparam int unsigned DEF_NTHR = 4;
    localparam int unsigned DEF_PW   = 9;
endpackage

// File: rtl/steer_elig.sv
module steer_elig #(
    parameter int unsigned NIRQ = 8,
    parameter int unsigned NTHR = 4
) (
    input  logic                   glb_ie,
    input  logic [NTHR-1:0]        thr_ie,
    input  logic [NTHR-1:0]        exc_q,
    input  logic [NTHR*NIRQ-1:0]   thr_mask,
    output logic [NIRQ*NTHR-1:0]   elig,
    output logic [NIRQ-1:0]        irq_ok
);
    // elig is laid out line-major: bit i*NTHR+t
    for (genvar gi = 0; gi < NIRQ; gi++) begin : g_irq
        for (genvar gt = 0; gt < NTHR; gt++) begin : g_thr
            assign elig[gi*NTHR+gt] = glb_ie & thr_ie[gt] & ~exc_q[gt]
                                      & ~thr_mask[gt*NIRQ+gi];
        end
        assign irq_ok[gi] = |elig[gi*NTHR +: NTHR];
    end
endmodule

// File: rtl/steer_irq_pick.sv
module steer_irq_pick #(
    parameter int unsigned NIRQ = 8,
    localparam int unsigned IW  = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic [NIRQ-1:0] cand,
    output logic            vld,
    output logic [IW-1:0]   idx
);
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (cand[i]) begin
                vld = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/steer_thr_pick.sv
module steer_thr_pick #(
    parameter int unsigned NTHR = 4,
    parameter int unsigned PW   = 9
) (
    input  logic [NTHR-1:0]    row,
    input  logic [NTHR*PW-1:0] prio,
    output logic [NTHR-1:0]    sel
);
    logic [PW-1:0] best;
    logic          found;

    always_comb begin
        best  = '0;
        found = 1'b0;
        sel   = '0;
        for (int t = 0; t < NTHR; t++) begin
            // strict compare keeps the lower index on a tie
            if (row[t] && (!found || prio[t*PW +: PW] > best)) begin
                best  = prio[t*PW +: PW];
                found = 1'b1;
                sel   = '0;
                sel[t] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/steer_resched.sv
module steer_resched #(
    parameter int unsigned NTHR = 4,
    parameter int unsigned PW   = 9
) (
    input  logic               sched_en,
    input  logic [NTHR*PW-1:0] prio,
    input  logic [PW-1:0]      bestwait,
    output logic               fire
);
    logic [NTHR-1:0] worse;

    for (genvar gt = 0; gt < NTHR; gt++) begin : g_cmp
        assign worse[gt] = prio[gt*PW +: PW] > bestwait;
    end

    assign fire = sched_en & (|worse);
endmodule

// File: rtl/steer_top.sv
module steer_top
    import steer_pkg::*;
#(
    parameter int unsigned NIRQ = DEF_NIRQ,
    parameter int unsigned NTHR = DEF_NTHR,
    parameter int unsigned PW   = DEF_PW,
    localparam int unsigned IW  = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NIRQ-1:0]      irq_in,
    input  logic                 glb_ie,
    input  logic [NTHR-1:0]      thr_ie,
    input  logic [NTHR*PW-1:0]   thr_prio,
    input  logic [NTHR*NIRQ-1:0] thr_mask,
    input  logic [NTHR-1:0]      exc_clr,
    input  logic                 sched_en,
    input  logic                 bw_wr,
    input  logic [PW-1:0]        bw_wdata,
    output logic                 grant_vld,
    output logic [NTHR-1:0]      grant_thr,
    output logic [IW-1:0]        grant_irq,
    output logic [NTHR-1:0]      exc_mode,
    output logic                 resched_req,
    output logic [PW-1:0]        bestwait
);
    typedef struct packed {
        logic [NIRQ-1:0] pend;
        logic [NTHR-1:0] exc;
        logic            gv;
        logic [NTHR-1:0] gthr;
        logic [IW-1:0]   girq;
        logic            rs;
        logic [PW-1:0]   bw;
    } st_t;

    st_t st_q, st_d;

    logic [NIRQ*NTHR-1:0] elig;
    logic [NIRQ-1:0]      irq_ok;
    logic [NIRQ-1:0]      eff_pend;
    logic [NIRQ-1:0]      cand;
    logic                 pick_vld;
    logic [IW-1:0]        pick_idx;
    logic [NTHR-1:0]      row;
    logic [NTHR-1:0]      thr_sel;
    logic                 fire;

    steer_elig #(.NIRQ(NIRQ), .NTHR(NTHR)) u_elig (
        .glb_ie   (glb_ie),
        .thr_ie   (thr_ie),
        .exc_q    (st_q.exc),
        .thr_mask (thr_mask),
        .elig     (elig),
        .irq_ok   (irq_ok)
    );

    assign eff_pend = st_q.pend | irq_in;
    assign cand     = eff_pend & irq_ok;

    steer_irq_pick #(.NIRQ(NIRQ)) u_irq (
        .cand (cand),
        .vld  (pick_vld),
        .idx  (pick_idx)
    );

    assign row = elig[pick_idx*NTHR +: NTHR];

    steer_thr_pick #(.NTHR(NTHR), .PW(PW)) u_thr (
        .row  (row),
        .prio (thr_prio),
        .sel  (thr_sel)
    );

    steer_resched #(.NTHR(NTHR), .PW(PW)) u_rs (
        .sched_en (sched_en),
        .prio     (thr_prio),
        .bestwait (st_q.bw),
        .fire     (fire)
    );

    always_comb begin
        st_d = st_q;
        // pending set: capture new lines, drop the one granted now
        st_d.pend = eff_pend;
        if (pick_vld) begin
            st_d.pend[pick_idx] = 1'b0;
        end
        // exception mode: clear first, a fresh grant overrides
        st_d.exc  = (st_q.exc & ~exc_clr) | (pick_vld ? thr_sel : '0);
        st_d.gv   = pick_vld;
        st_d.gthr = pick_vld ? thr_sel : '0;
        st_d.girq = pick_vld ? pick_idx : '0;
        // reschedule pulse and best-wait rearm; software write wins
        st_d.rs   = fire;
        if (bw_wr) begin
            st_d.bw = bw_wdata;
        end else if (fire) begin
            st_d.bw = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.bw   <= '1;
        end else begin
            st_q      <= st_d;
        end
    end

    assign grant_vld   = st_q.gv;
    assign grant_thr   = st_q.gthr;
    assign grant_irq   = st_q.girq;
    assign exc_mode    = st_q.exc;
    assign resched_req = st_q.rs;
    assign bestwait    = st_q.bw;
endmodule

// File: rtl/steer_chk.sv
module steer_chk #(
    parameter int unsigned NTHR = 4,
    parameter int unsigned PW   = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            glb_ie,
    input logic            sched_en,
    input logic            bw_wr,
    input logic [PW-1:0]   bw_wdata,
    input logic            grant_vld,
    input logic [NTHR-1:0] grant_thr,
    input logic [NTHR-1:0] exc_mode,
    input logic            resched_req,
    input logic [PW-1:0]   bestwait
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> $onehot(grant_thr)); // R10

    AST_IDLE_NO_THREAD: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_vld |-> (grant_thr == '0)); // R10

    AST_GRANT_MARKS_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> ((exc_mode & grant_thr) == grant_thr)); // R6

    AST_GIE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_ie |=> !grant_vld); // R2

    AST_SCHED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !sched_en |=> !resched_req); // R8

    AST_BW_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (resched_req && !$past(bw_wr)) |-> (bestwait == '1)); // R7

    AST_RS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (resched_req && bestwait == '1 && !bw_wr) |=> !resched_req); // R7

    AST_BW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bw_wr |=> (bestwait == $past(bw_wdata))); // R9
endmodule

bind steer_top steer_chk #(.NTHR(NTHR), .PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .glb_ie      (glb_ie),
    .sched_en    (sched_en),
    .bw_wr       (bw_wr),
    .bw_wdata    (bw_wdata),
    .grant_vld   (grant_vld),
    .grant_thr   (grant_thr),
    .exc_mode    (exc_mode),
    .resched_req (resched_req),
    .bestwait    (bestwait)
);

// File: tb/sim_steer_top.sv
module sim_steer_top;
    localparam int NIRQ = 8;
    localparam int NTHR = 4;
    localparam int PW   = 9;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [NIRQ-1:0]      irq_in;
    logic                 glb_ie;
    logic [NTHR-1:0]      thr_ie;
    logic [NTHR*PW-1:0]   thr_prio;
    logic [NTHR*NIRQ-1:0] thr_mask;
    logic [NTHR-1:0]      exc_clr;
    logic                 sched_en;
    logic                 bw_wr;
    logic [PW-1:0]        bw_wdata;
    logic                 grant_vld;
    logic [NTHR-1:0]      grant_thr;
    logic [2:0]           grant_irq;
    logic [NTHR-1:0]      exc_mode;
    logic                 resched_req;
    logic [PW-1:0]        bestwait;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    steer_top u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .glb_ie(glb_ie),
        .thr_ie(thr_ie), .thr_prio(thr_prio), .thr_mask(thr_mask),
        .exc_clr(exc_clr), .sched_en(sched_en), .bw_wr(bw_wr),
        .bw_wdata(bw_wdata), .grant_vld(grant_vld), .grant_thr(grant_thr),
        .grant_irq(grant_irq), .exc_mode(exc_mode),
        .resched_req(resched_req), .bestwait(bestwait)
    );

    // {prio3, prio2, prio1, prio0, thread enables, expected one-hot grant}
    localparam logic [43:0] VTAB [6] = '{
        {9'd40,  9'd30,  9'd20,  9'd10,  4'b1111, 4'b1000},
        {9'd40,  9'd30,  9'd20,  9'd50,  4'b1111, 4'b0001},
        {9'd7,   9'd100, 9'd100, 9'd5,   4'b1111, 4'b0010},
        {9'h1ff, 9'h1ff, 9'h1ff, 9'h1ff, 4'b1111, 4'b0001},
        {9'd40,  9'd30,  9'd20,  9'd10,  4'b0111, 4'b0100},
        {9'd0,   9'd0,   9'd0,   9'd300, 4'b1110, 4'b0010}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clr_all();
        exc_clr = '1;
        tick();
        exc_clr = '0;
    endtask

    task automatic chk_grant(input string req, input int irq, input int thr);
        chk(grant_vld == 1'b1, req, int'(grant_vld), 1);
        chk(grant_irq == 3'(irq), req, int'(grant_irq), irq);
        chk(grant_thr == 4'(thr), req, int'(grant_thr), thr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired before the test sequence ended");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_in = '0; glb_ie = 1'b0; thr_ie = '0; thr_prio = '0;
        thr_mask = '0; exc_clr = '0; sched_en = 1'b0; bw_wr = 1'b0; bw_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(grant_vld == 0, "R1 grant_vld", int'(grant_vld), 0);
        chk(grant_thr == 0, "R1 grant_thr", int'(grant_thr), 0);
        chk(exc_mode == 0, "R1 exc_mode", int'(exc_mode), 0);
        chk(resched_req == 0, "R1 resched", int'(resched_req), 0);
        chk(bestwait == 9'h1ff, "R1 bestwait", int'(bestwait), 'h1ff);
        tick();
        chk(grant_vld == 0, "R1 nothing pending", int'(grant_vld), 0);

        // R3 / R2 / R10 table: priority selection, ties, thread enables
        glb_ie = 1'b1;
        for (int v = 0; v < 6; v++) begin
            thr_prio = VTAB[v][43:8];
            thr_ie   = VTAB[v][7:4];
            clr_all();
            irq_in = 8'h01;
            tick();
            irq_in = '0;
            chk_grant("R3 table", 0, int'(VTAB[v][3:0]));
        end

        // R2 global disable holds the line pending; R5 grant once enabled
        thr_ie = '1; thr_prio = '0;
        clr_all();
        glb_ie = 1'b0;
        irq_in = 8'h04;
        tick();
        irq_in = '0;
        chk(grant_vld == 0, "R2 glb_ie off", int'(grant_vld), 0);
        tick();
        chk(grant_vld == 0, "R5 still waiting", int'(grant_vld), 0);
        glb_ie = 1'b1;
        tick();
        chk_grant("R5 late grant", 2, 1);

        // R2 mask bit of thread 0 for line 3
        clr_all();
        thr_mask[0*NIRQ+3] = 1'b1;
        irq_in = 8'h08;
        tick();
        irq_in = '0;
        chk_grant("R2 mask", 3, 2);
        thr_mask = '0;

        // R2 / R6 exception mode excludes threads
        irq_in = 8'h40;
        tick();
        chk_grant("R6 free thread", 6, 1);
        tick();
        irq_in = '0;
        chk_grant("R2 exc excludes", 6, 4);
        chk(exc_mode == 4'b0111, "R6 exc bits", int'(exc_mode), 7);

        // R6 set wins over a simultaneous clear
        clr_all();
        exc_clr = 4'b0001;
        irq_in = 8'h80;
        tick();
        irq_in = '0; exc_clr = '0;
        chk_grant("R6 collision", 7, 1);
        chk(exc_mode == 4'b0001, "R6 set wins", int'(exc_mode), 1);

        // R4 two lines together: lowest first, one per clock
        clr_all();
        irq_in = 8'h22;
        tick();
        irq_in = '0;
        chk_grant("R4 first", 1, 1);
        tick();
        chk_grant("R4 second", 5, 2);
        tick();
        chk(grant_vld == 0, "R10 pulse ends", int'(grant_vld), 0);

        // R4 a blocked lower line does not stall a higher one; R5 later
        clr_all();
        thr_mask = 32'h0101_0101;
        irq_in = 8'h11;
        tick();
        irq_in = '0;
        chk_grant("R4 skip blocked", 4, 1);
        tick();
        chk(grant_vld == 0, "R5 masked waits", int'(grant_vld), 0);
        thr_mask = '0;
        tick();
        chk_grant("R5 unmasked", 0, 2);

        // R9 write, R7 no trigger below threshold
        sched_en = 1'b1;
        thr_prio = {9'd80, 9'd70, 9'd60, 9'd50};
        bw_wr = 1'b1; bw_wdata = 9'd100;
        tick();
        bw_wr = 1'b0;
        chk(bestwait == 9'd100, "R9 write", int'(bestwait), 100);
        tick(); tick();
        chk(resched_req == 0, "R7 no trigger", int'(resched_req), 0);

        // R7 trigger in the same cycle as a grant
        clr_all();
        thr_prio = {9'd80, 9'd150, 9'd60, 9'd50};
        irq_in = 8'h04;
        tick();
        irq_in = '0;
        chk(resched_req == 1, "R7 fire", int'(resched_req), 1);
        chk(bestwait == 9'h1ff, "R7 rearm", int'(bestwait), 'h1ff);
        chk_grant("R3 with resched", 2, 4);
        tick();
        chk(resched_req == 0, "R7 single pulse", int'(resched_req), 0);

        // R8 scheduler disabled
        sched_en = 1'b0;
        bw_wr = 1'b1; bw_wdata = 9'd100;
        tick();
        bw_wr = 1'b0;
        tick(); tick();
        chk(resched_req == 0, "R8 off", int'(resched_req), 0);
        chk(bestwait == 9'd100, "R8 no rearm", int'(bestwait), 100);

        // R9 write collides with a trigger
        sched_en = 1'b1;
        bw_wr = 1'b1; bw_wdata = 9'd50;
        tick();
        bw_wr = 1'b0;
        chk(resched_req == 1, "R9 fire", int'(resched_req), 1);
        chk(bestwait == 9'd50, "R9 write wins", int'(bestwait), 50);
        tick();
        chk(resched_req == 1, "R7 refire", int'(resched_req), 1);
        chk(bestwait == 9'h1ff, "R7 rearm again", int'(bestwait), 'h1ff);
        tick();
        chk(resched_req == 0, "R7 quiet", int'(resched_req), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule